// File: doc/BRIEF.md
# SD Response Capture

This block listens to the card's CMD line once the host has fired a command and brings in the card's reply. The command issuer starts a capture with a one-cycle `cmd_fire` pulse and, in the same cycle, gives the kind of response it expects. From then on the block samples `cmd_in` only in cycles where the `sd_clk_rise` strobe is high. It finds the start bit and shifts in either a 48-bit or a 136-bit frame. Where the response kind carries a CRC7, the block checks it.

Captured bits are read back as eight 16-bit words, chosen by `rd_sel`. The layout is fixed so that software can rebuild the result directly:
- A short reply fills words 0 to 2, shifted by one byte, so the 32-bit card status is `(w0 >> 8) | (w1 << 8) | (w2 << 24)`.
- A long reply drops its trailing CRC byte and keeps exactly 128 bits.
- The busy-signalling kind additionally holds completion until the card releases DAT0.

The controller is one state machine with these states:
- ST_IDLE: after reset.
- ST_ARM: waiting for a high CMD sample.
- ST_HUNT: waiting for the low start bit.
- ST_SHIFT: bits are being received.
- ST_BUSY: waiting for DAT0 to go high.
- ST_DONE: the response is ready.

Its transitions are:
- fire-with-response: any state to ST_ARM.
- fire-no-response: any state to ST_DONE.
- line-high: ST_ARM to ST_HUNT.
- start-bit: ST_HUNT to ST_SHIFT.
- frame-end-busy: ST_SHIFT to ST_BUSY.
- frame-end: ST_SHIFT to ST_DONE.
- busy-release: ST_BUSY to ST_DONE.

Top module: `sd_rsp_capture`

## Requirements
- R1: After reset, `rsp_ready` and `crc_err` are 0 and all eight read words are 0.
- R2: After a fire, a low CMD sample is accepted as a start bit only once at least one high CMD sample has been seen since that fire. Low samples before that are ignored.
- R3: The `rsp_kind` code is 1 (short), 2 (short with busy) or 3 (short, no CRC check) for a 48-bit frame. Frame bit 47 is the start bit. Word 0 holds frame bits 15:0, word 1 holds bits 31:16 and word 2 holds bits 47:32, so `(w0>>8)|(w1<<8)|(w2<<24)` equals frame bits 39:8. Words 3 to 7 read 0. `rsp_ready` rises in the cycle after the strobe that samples the last bit.
- R4: The `rsp_kind` code 4 (long) selects a 136-bit frame. Only frame bits 135:8 are stored: word i holds frame bits 16i+23 down to 16i+8, so words 0 and 1 form the least significant 32 bits and words 6 and 7 the most significant.
- R5: The CRC7 uses polynomial x^7+x^3+1 with initial value 0. For a short frame it covers frame bits 47:8; for a long frame it covers frame bits 127:8. It is compared with frame bits 7:1. A mismatch sets `crc_err` in the same cycle `rsp_ready` (or the busy wait) begins, and the stored words are still kept.
- R6: For kind 3, `crc_err` stays 0 whatever the CRC field holds.
- R7: For kind 2, `rsp_ready` stays 0 after the frame until a strobe samples `dat0_in` high. The ready bit rises in the next cycle.
- R8: For kind 0 (no response), `rsp_ready` is 1 in the cycle after the fire, and no CMD sampling is needed.
- R9: A fire in any state clears `rsp_ready`, `crc_err` and all stored words in the next cycle, and abandons any capture in progress.
- R10: Neither CMD nor DAT0 levels have any effect in cycles where `sd_clk_rise` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_fire | input | 1 | One-cycle pulse when a command is issued |
| rsp_kind | input | 3 | Expected response kind, valid with `cmd_fire` (0 none, 1 short, 2 short+busy, 3 short no CRC, 4 long) |
| sd_clk_rise | input | 1 | Strobe marking a rising card clock; samples are taken only then |
| cmd_in | input | 1 | CMD line level |
| dat0_in | input | 1 | DAT0 line level, low while the card is busy |
| rd_sel | input | 3 | Read word index |
| rd_word | output | 16 | Selected captured word |
| rsp_ready | output | 1 | Response captured (and busy released) |
| crc_err | output | 1 | CRC7 mismatch in the captured response |

## Verification
Short frames are swept over many command indices and argument values, with idle gaps of zero to two cycles. During each gap the CMD line carries the inverse of the bit just sent, which separates correct strobe qualification from sampling on every clock. Long frames with varied content check the word order and the dropped CRC byte. Single-bit CRC corruptions are applied to short, long and no-check kinds, which tells the CRC window apart from the compare window and from the per-kind check gating. A low CMD line before the first high sample, a restart fired in the middle of a long frame, and a held DAT0 busy each expose a distinct misalignment or early-ready fault.

// File: rtl/sdrc_pkg.sv
package sdrc_pkg;

    typedef enum logic [2:0] {
        RK_NONE        = 3'd0,
        RK_SHORT       = 3'd1,
        RK_SHORT_BUSY  = 3'd2,
        RK_SHORT_NOCRC = 3'd3,
        RK_LONG        = 3'd4
    } rsp_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_HUNT,
        ST_SHIFT,
        ST_BUSY,
        ST_DONE
    } cap_state_e;

endpackage

// File: rtl/sdrc_crc7.sv
module sdrc_crc7 #(
    parameter int            CRC_W = 7,
    parameter logic [CRC_W-1:0] POLY = 7'h09
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic upd,
    input  logic cmp,
    input  logic din,
    output logic mism
);

    logic [CRC_W-1:0] crc_q;
    logic             fb;

    assign fb = din ^ crc_q[CRC_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            crc_q <= '0;
            mism  <= 1'b0;
        end else if (upd) begin
            crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end else if (cmp) begin
            crc_q <= {crc_q[CRC_W-2:0], 1'b0};
            mism  <= mism | fb;
        end
    end

    AST_CRC_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (mism && !clr) |=> mism);  // R5

endmodule

// File: rtl/sdrc_store.sv
module sdrc_store #(
    parameter int REG_W = 16,
    parameter int NREG  = 8,
    localparam int BITS  = REG_W * NREG,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift_en,
    input  logic             din,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [REG_W-1:0] rd_word
);

    logic [BITS-1:0]  sr_q;
    logic [REG_W-1:0] words [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sr_q <= '0;
        end else if (shift_en) begin
            sr_q <= {sr_q[BITS-2:0], din};
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_word
        assign words[g] = sr_q[g*REG_W +: REG_W];
    end

    assign rd_word = words[rd_sel];

endmodule

// File: rtl/sd_rsp_capture.sv
module sd_rsp_capture
    import sdrc_pkg::*;
#(
    parameter int REG_W     = 16,
    parameter int NREG      = 8,
    parameter int SHORT_LEN = 48,
    parameter int LONG_LEN  = 136,
    parameter int CRC_W     = 7,
    localparam int SEL_W    = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_fire,
    input  logic [2:0]       rsp_kind,
    input  logic             sd_clk_rise,
    input  logic             cmd_in,
    input  logic             dat0_in,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [REG_W-1:0] rd_word,
    output logic             rsp_ready,
    output logic             crc_err
);

    localparam int STORE_BITS = REG_W * NREG;
    localparam int CNT_W      = $clog2(LONG_LEN + 1);
    localparam int TAIL_BITS  = CRC_W + 1;
    localparam int LONG_HDR   = LONG_LEN - STORE_BITS;

    cap_state_e       state_q, state_d;
    rsp_kind_e        kind_q;
    logic [CNT_W-1:0] bit_cnt;
    logic [CNT_W-1:0] bit_no;
    logic [CNT_W-1:0] frame_len;
    logic [CNT_W-1:0] cov_first;
    logic             is_long;
    logic             shift_cyc;
    logic             last_bit;
    logic             crc_upd;
    logic             crc_cmp;
    logic             store_en;
    logic             crc_mism;
    logic             err_q;
    logic             start_seen;

    assign is_long   = (kind_q == RK_LONG);
    assign frame_len = is_long ? CNT_W'(LONG_LEN) : CNT_W'(SHORT_LEN);
    assign cov_first = is_long ? CNT_W'(LONG_HDR + 1) : CNT_W'(2);
    assign bit_no    = bit_cnt + CNT_W'(1);
    assign shift_cyc = sd_clk_rise && !cmd_fire && (state_q == ST_SHIFT);
    assign last_bit  = (bit_no == frame_len);
    assign crc_upd   = shift_cyc && (bit_no >= cov_first) && (bit_no <= frame_len - CNT_W'(TAIL_BITS));
    assign crc_cmp   = shift_cyc && (bit_no > frame_len - CNT_W'(TAIL_BITS)) && !last_bit;
    assign store_en  = shift_cyc && (bit_cnt < CNT_W'(STORE_BITS));
    assign start_seen = sd_clk_rise && !cmd_fire && (state_q == ST_HUNT) && !cmd_in;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (cmd_fire) begin
            state_d = (rsp_kind_e'(rsp_kind) == RK_NONE) ? ST_DONE : ST_ARM;
        end else if (sd_clk_rise) begin
            unique case (state_q)
                ST_IDLE:  begin end
                ST_ARM:   if (cmd_in)   state_d = ST_HUNT;
                ST_HUNT:  if (!cmd_in)  state_d = ST_SHIFT;
                ST_SHIFT: if (last_bit) state_d = (kind_q == RK_SHORT_BUSY) ? ST_BUSY : ST_DONE;
                ST_BUSY:  if (dat0_in)  state_d = ST_DONE;
                ST_DONE:  begin end
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Capture bookkeeping registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= RK_NONE;
            bit_cnt <= '0;
            err_q   <= 1'b0;
        end else if (cmd_fire) begin
            kind_q  <= rsp_kind_e'(rsp_kind);
            bit_cnt <= '0;
            err_q   <= 1'b0;
        end else if (start_seen) begin
            bit_cnt <= CNT_W'(1);
        end else if (shift_cyc) begin
            bit_cnt <= bit_no;
            if (last_bit) begin
                err_q <= crc_mism && (kind_q != RK_SHORT_NOCRC);
            end
        end
    end

    // Outputs
    always_comb begin
        rsp_ready = (state_q == ST_DONE);
        crc_err   = err_q;
    end

    sdrc_crc7 #(
        .CRC_W (CRC_W),
        .POLY  (CRC_W'(7'h09))
    ) i_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cmd_fire),
        .upd   (crc_upd),
        .cmp   (crc_cmp),
        .din   (cmd_in),
        .mism  (crc_mism)
    );

    sdrc_store #(
        .REG_W (REG_W),
        .NREG  (NREG)
    ) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cmd_fire),
        .shift_en (store_en),
        .din      (cmd_in),
        .rd_sel   (rd_sel),
        .rd_word  (rd_word)
    );

    AST_READY_CLR_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n) (cmd_fire && rsp_kind != 3'd0) |=> !rsp_ready);  // R9
    AST_NONE_READY: assert property (@(posedge clk) disable iff (!rst_n) (cmd_fire && rsp_kind == 3'd0) |=> rsp_ready);  // R8
    AST_NOCRC_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n) (kind_q == RK_SHORT_NOCRC) |-> !crc_err);  // R6
    AST_ERR_AT_END: assert property (@(posedge clk) disable iff (!rst_n) crc_err |-> (state_q == ST_DONE || state_q == ST_BUSY));  // R5
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_BUSY && !cmd_fire && !(sd_clk_rise && dat0_in)) |=> (state_q == ST_BUSY));  // R7
    AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!sd_clk_rise && !cmd_fire) |=> ($stable(state_q) && $stable(bit_cnt)));  // R10
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) bit_cnt <= CNT_W'(LONG_LEN));  // R4
    AST_ARM_NO_START: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_ARM && !cmd_fire) |=> (state_q != ST_SHIFT));  // R2

endmodule

// File: tb/test_sd_rsp_capture.sv
module test_sd_rsp_capture;

    logic        clk = 1'b0;
    logic        rst_n, cmd_fire, sd_clk_rise, cmd_in, dat0_in;
    logic [2:0]  rsp_kind, rd_sel;
    logic [15:0] rd_word;
    logic        rsp_ready, crc_err;
    int          checks = 0;
    int          failures = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    sd_rsp_capture i_sd_rsp_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_fire    (cmd_fire),
        .rsp_kind    (rsp_kind),
        .sd_clk_rise (sd_clk_rise),
        .cmd_in      (cmd_in),
        .dat0_in     (dat0_in),
        .rd_sel      (rd_sel),
        .rd_word     (rd_word),
        .rsp_ready   (rsp_ready),
        .crc_err     (crc_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] crc7_of(input logic [135:0] v, input int hi, input int lo);
        logic [6:0] c = '0;
        for (int i = hi; i >= lo; i--) begin
            logic fb;
            fb = v[i] ^ c[6];
            c  = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    function automatic logic [135:0] mk_short(input logic [5:0] idx, input logic [31:0] arg, input logic bad);
        logic [135:0] v = '0;
        v[47:8] = {2'b00, idx, arg};
        v[7:1]  = crc7_of(v, 47, 8) ^ (bad ? 7'h04 : 7'h00);
        v[0]    = 1'b1;
        return v;
    endfunction

    function automatic logic [135:0] mk_long(input int seed, input logic bad);
        logic [135:0] v = '0;
        logic [127:0] c = '0;
        for (int w = 0; w < 4; w++) begin
            c[32*w +: 32] = 32'(seed * 7 + w) * 32'h9E3779B9 + 32'hA5A50000;
        end
        v[135:128] = 8'h3F;
        v[127:8]   = c[119:0];
        v[7:1]     = crc7_of(v, 127, 8) ^ (bad ? 7'h10 : 7'h00);
        v[0]       = 1'b1;
        return v;
    endfunction

    task automatic strobe(input logic c, input logic d);
        @(negedge clk);
        cmd_in = c;
        dat0_in = d;
        sd_clk_rise = 1'b1;
        @(negedge clk);
        sd_clk_rise = 1'b0;
    endtask

    task automatic fire(input logic [2:0] k);
        @(negedge clk);
        cmd_fire = 1'b1;
        rsp_kind = k;
        @(negedge clk);
        cmd_fire = 1'b0;
        if (k != 3'd0) chk("R9 ready cleared by fire", 32'(rsp_ready), 32'd0);
    endtask

    // Preamble arms the block, then bits with gaps carrying the opposite level
    task automatic send_bits(input logic [135:0] v, input int len, input int upto, input int gap);
        strobe(1'b1, 1'b1);
        cmd_in = 1'b0;
        repeat (gap) @(negedge clk);
        strobe(1'b1, 1'b1);
        for (int i = len - 1; i >= upto; i--) begin
            strobe(v[i], 1'b1);
            cmd_in = ~v[i];
            repeat (gap) @(negedge clk);
        end
        cmd_in = 1'b1;
    endtask

    task automatic check_store(input logic [135:0] v, input bit is_long, input string req);
        logic [15:0] w [3];
        for (int r = 0; r < 8; r++) begin
            logic [15:0] exp;
            rd_sel = 3'(r);
            #1;
            exp = is_long ? v[8 + 16*r +: 16] : ((r < 3) ? v[16*r +: 16] : 16'h0);
            chk(req, 32'(rd_word), 32'(exp));
            if (r < 3) w[r] = rd_word;
        end
        if (!is_long) begin
            chk("R3 payload reassembly", (32'(w[0]) >> 8) | (32'(w[1]) << 8) | (32'(w[2]) << 24), v[39:8]);
        end
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired act=hung exp=finished");
            finish_run();
        end
    end

    initial begin
        logic [135:0] v;
        rst_n = 1'b0; cmd_fire = 1'b0; sd_clk_rise = 1'b0;
        cmd_in = 1'b1; dat0_in = 1'b1; rsp_kind = 3'd0; rd_sel = 3'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ready at reset", 32'(rsp_ready), 32'd0);
        chk("R1 crc_err at reset", 32'(crc_err), 32'd0);
        for (int r = 0; r < 8; r++) begin
            rd_sel = 3'(r);
            #1;
            chk("R1 word zero at reset", 32'(rd_word), 32'd0);
        end

        // R8 no-response kind
        fire(3'd0);
        chk("R8 ready after no-response fire", 32'(rsp_ready), 32'd1);
        chk("R8 no crc_err", 32'(crc_err), 32'd0);

        // R3 short sweep with gaps (R10)
        for (int i = 0; i < 10; i++) begin
            v = mk_short(6'(i * 11), 32'(i) * 32'h9E3779B9 + 32'h1357, 1'b0);
            fire(3'd1);
            send_bits(v, 48, 0, i % 3);
            chk("R3 ready after short frame", 32'(rsp_ready), 32'd1);
            chk("R5 no crc_err good short", 32'(crc_err), 32'd0);
            check_store(v, 1'b0, "R3 short word layout R10");
        end

        // R5 corrupted short CRC
        for (int i = 0; i < 3; i++) begin
            v = mk_short(6'(i + 17), 32'hDEAD0000 | 32'(i), 1'b1);
            fire(3'd1);
            send_bits(v, 48, 0, i);
            chk("R5 ready on bad short", 32'(rsp_ready), 32'd1);
            chk("R5 crc_err on bad short", 32'(crc_err), 32'd1);
            check_store(v, 1'b0, "R5 words kept on bad crc");
        end

        // R6 no-check kind with bad and good CRC
        for (int i = 0; i < 2; i++) begin
            v = mk_short(6'h3F, 32'h80FF8000 ^ 32'(i), i == 0);
            fire(3'd3);
            send_bits(v, 48, 0, 1);
            chk("R6 ready no-check kind", 32'(rsp_ready), 32'd1);
            chk("R6 crc_err suppressed", 32'(crc_err), 32'd0);
        end

        // R7 busy kind, good and bad CRC
        for (int i = 0; i < 2; i++) begin
            v = mk_short(6'd7, 32'h00000900 + 32'(i), i == 1);
            fire(3'd2);
            send_bits(v, 48, 0, 0);
            chk("R7 not ready while busy", 32'(rsp_ready), 32'd0);
            repeat (4) strobe(1'b1, 1'b0);
            chk("R7 not ready dat0 low", 32'(rsp_ready), 32'd0);
            dat0_in = 1'b1;
            repeat (3) @(negedge clk);
            chk("R10 dat0 high without strobe ignored", 32'(rsp_ready), 32'd0);
            strobe(1'b1, 1'b1);
            chk("R7 ready after busy release", 32'(rsp_ready), 32'd1);
            chk("R5 crc_err with busy kind", 32'(crc_err), 32'(i));
            check_store(v, 1'b0, "R7 busy words");
        end

        // R4 long sweep
        for (int i = 0; i < 5; i++) begin
            v = mk_long(i, 1'b0);
            fire(3'd4);
            send_bits(v, 136, 0, i % 2);
            chk("R4 ready after long", 32'(rsp_ready), 32'd1);
            chk("R5 no crc_err good long", 32'(crc_err), 32'd0);
            check_store(v, 1'b1, "R4 long word layout");
        end
        v = mk_long(9, 1'b1);
        fire(3'd4);
        send_bits(v, 136, 0, 0);
        chk("R5 crc_err on bad long", 32'(crc_err), 32'd1);
        check_store(v, 1'b1, "R4 long words kept");

        // R2 low line before any high sample after fire
        v = mk_short(6'd13, 32'h12345678, 1'b0);
        fire(3'd1);
        repeat (3) strobe(1'b0, 1'b1);
        chk("R2 no ready from early low", 32'(rsp_ready), 32'd0);
        send_bits(v, 48, 0, 0);
        chk("R2 ready after armed frame", 32'(rsp_ready), 32'd1);
        chk("R2 no crc_err armed frame", 32'(crc_err), 32'd0);
        check_store(v, 1'b0, "R2 aligned words");

        // R9 restart in the middle of a long frame
        v = mk_long(3, 1'b0);
        fire(3'd4);
        send_bits(v, 136, 76, 0);
        v = mk_short(6'd41, 32'hCAFEF00D, 1'b0);
        fire(3'd1);
        for (int r = 0; r < 8; r++) begin
            rd_sel = 3'(r);
            #1;
            chk("R9 words cleared by fire", 32'(rd_word), 32'd0);
        end
        send_bits(v, 48, 0, 0);
        chk("R9 ready after restart", 32'(rsp_ready), 32'd1);
        chk("R9 no crc_err after restart", 32'(crc_err), 32'd0);
        check_store(v, 1'b0, "R9 restarted words");

        finish_run();
    end

endmodule